// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block takes a raw 32-bit IEEE-754 single precision pattern and produces the 16-bit half precision pattern nearest to it. Rounding is to nearest, and a value exactly halfway between two results goes to the one with an even last bit. Values too large for the narrow format become infinity. Values too small become a subnormal result or a signed zero. NaNs keep as much of their payload as fits in the narrow field, and they never turn into infinity.

The conversion itself is purely combinational. A single register stage with a valid/ready handshake on both sides follows it. A result appears one cycle after the input is accepted. While the consumer stalls, the stage holds that result and refuses new input.

Top module: `fp_narrow_conv`

## Requirements
- R1: Output bit 15 equals input bit 31 for every input, including zero, infinity and NaN.
- R2: An input with biased exponent (bits 30:23) of 143 to 254 becomes signed infinity: bits 14:10 all ones and bits 9:0 zero. Exponent 255 with mantissa (bits 22:0) zero also becomes signed infinity.
- R3: An input with exponent 255 and a nonzero mantissa becomes a NaN. Its output bits 9:0 are input bits 22:13, except that when those bits are all zero, output bits 9:0 become 1.
- R4: An input with exponent below 102 becomes signed zero (bits 14:0 zero).
- R5: An input with exponent 102 to 112 becomes a subnormal result. The mantissa with its hidden one is shifted right by (113 − exponent) and rounded by R7, with all bits lost in the shift counted as sticky. A carry out of the 10-bit field gives the smallest normal value, 0x0400.
- R6: An input with exponent 113 to 142 gives output exponent bits 14:10 equal to the input exponent minus 112, or that value plus one when rounding carries.
- R7: Rounding adds one at the kept LSB when the first dropped bit is 1. The add is skipped when the dropped part is exactly one half and the kept LSB is 0.
- R8: A carry from rounding propagates into the exponent. An input with exponent 142 that rounds up past the largest finite value becomes infinity (0x7c00 with the sign).
- R9: An accepted input shows its result on the output one cycle later with the valid flag set. While the output is valid and not taken, the output is held and the ready flag to the producer is low.
- R10: During reset and right after it, the output valid flag is low, whatever the input valid flag was during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Producer presents a single precision pattern |
| in_ready_o | output | 1 | Stage can take a pattern this cycle |
| in_bits_i | input | 32 | Single precision bit pattern |
| out_valid_o | output | 1 | Half precision result is valid |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| out_bits_o | output | 16 | Half precision bit pattern |

## Verification
The bench builds the block with its default format widths: an 8-bit exponent and 23-bit mantissa on the source side, and a 5-bit exponent and 10-bit mantissa on the destination side. With these widths, every class threshold (exponents 101, 102, 112, 113, 142, 143, 254, 255) can be reached with directed patterns, and so can the exact-tie and carry-to-infinity cases. Random patterns are weighted toward the exponent window around the subnormal and overflow edges. Random stalls on the output side exercise the hold behaviour.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;
  localparam int unsigned SRC_EXP_W = 8;
  localparam int unsigned SRC_MAN_W = 23;
  localparam int unsigned DST_EXP_W = 5;
  localparam int unsigned DST_MAN_W = 10;

  localparam int unsigned SRC_W     = 1 + SRC_EXP_W + SRC_MAN_W;
  localparam int unsigned DST_W     = 1 + DST_EXP_W + DST_MAN_W;
  localparam int unsigned SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int unsigned DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int unsigned REBIAS    = SRC_BIAS - DST_BIAS;
  localparam int unsigned DROP_W    = SRC_MAN_W - DST_MAN_W;
  localparam int unsigned SHIFT_PAD = DST_MAN_W + 1;
  localparam int unsigned EXT_W     = SRC_MAN_W + 1 + SHIFT_PAD;

  // class thresholds on the biased source exponent
  localparam logic [SRC_EXP_W-1:0] EXP_OVF  = SRC_EXP_W'(REBIAS + (1 << DST_EXP_W) - 1);
  localparam logic [SRC_EXP_W-1:0] EXP_SUB  = SRC_EXP_W'(REBIAS - DST_MAN_W);
  localparam logic [SRC_EXP_W-1:0] EXP_NORM = SRC_EXP_W'(REBIAS + 1);
  localparam logic [SRC_EXP_W-1:0] EXP_REB  = SRC_EXP_W'(REBIAS);

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } cls_e;
endpackage

// File: rtl/fp_narrow_classify.sv
module fp_narrow_classify
  import fp_narrow_pkg::*;
(
  input  logic [SRC_EXP_W-1:0] exp_i,
  input  logic                 man_nz_i,
  output cls_e                 cls_o
);
  always_comb begin
    if (exp_i == '1)            cls_o = man_nz_i ? CLS_NAN : CLS_INF;
    else if (exp_i >= EXP_OVF)  cls_o = CLS_INF;
    else if (exp_i < EXP_SUB)   cls_o = CLS_ZERO;
    else if (exp_i < EXP_NORM)  cls_o = CLS_SUB;
    else                        cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fp_narrow_round.sv
module fp_narrow_round #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] keep_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  output logic [W-1:0] sum_o
);
  logic inc;
  // skip only on an exact tie with even LSB
  assign inc   = guard_i & (sticky_i | keep_i[0]);
  assign sum_o = keep_i + W'(inc);
endmodule

// File: rtl/fp_narrow_core.sv
module fp_narrow_core
  import fp_narrow_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  output logic [DST_W-1:0] dst_o
);
  localparam int unsigned SUB_W  = DST_MAN_W + 1;
  localparam int unsigned NORM_W = DST_EXP_W + DST_MAN_W;

  logic                 sign;
  logic [SRC_EXP_W-1:0] exp;
  logic [SRC_MAN_W-1:0] man;
  cls_e                 cls;

  assign sign = src_i[SRC_W-1];
  assign exp  = src_i[SRC_MAN_W +: SRC_EXP_W];
  assign man  = src_i[SRC_MAN_W-1:0];

  fp_narrow_classify i_cls (
    .exp_i    (exp),
    .man_nz_i (|man),
    .cls_o    (cls)
  );

  // subnormal path: align with the hidden one, keep every shifted-out bit
  logic [SRC_EXP_W-1:0] sh_amt;
  logic [EXT_W-1:0]     ext, shifted;
  logic [SUB_W-1:0]     sub_keep, sub_res;
  logic                 sub_guard, sub_sticky;

  assign sh_amt     = EXP_NORM - exp;
  assign ext        = {1'b1, man, {SHIFT_PAD{1'b0}}};
  assign shifted    = ext >> sh_amt;
  assign sub_keep   = shifted[EXT_W-1 -: SUB_W];
  assign sub_guard  = shifted[EXT_W-SUB_W-1];
  assign sub_sticky = |shifted[EXT_W-SUB_W-2:0];

  fp_narrow_round #(.W(SUB_W)) i_rnd_sub (
    .keep_i   (sub_keep),
    .guard_i  (sub_guard),
    .sticky_i (sub_sticky),
    .sum_o    (sub_res)
  );

  // normal path: rebias, carry may walk into the exponent and up to infinity
  logic [SRC_EXP_W-1:0] nexp;
  logic [NORM_W-1:0]    norm_keep, norm_res;

  assign nexp      = exp - EXP_REB;
  assign norm_keep = {nexp[DST_EXP_W-1:0], man[SRC_MAN_W-1 -: DST_MAN_W]};

  fp_narrow_round #(.W(NORM_W)) i_rnd_norm (
    .keep_i   (norm_keep),
    .guard_i  (man[DROP_W-1]),
    .sticky_i (|man[DROP_W-2:0]),
    .sum_o    (norm_res)
  );

  // NaN payload narrowing
  logic [DST_MAN_W-1:0] nan_pay;
  assign nan_pay = (man[SRC_MAN_W-1 -: DST_MAN_W] == '0) ? DST_MAN_W'(1)
                                                         : man[SRC_MAN_W-1 -: DST_MAN_W];

  logic [NORM_W-1:0] mag;
  always_comb begin
    unique case (cls)
      CLS_ZERO: mag = '0;
      CLS_SUB:  mag = NORM_W'(sub_res);
      CLS_NORM: mag = norm_res;
      CLS_INF:  mag = {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
      CLS_NAN:  mag = {{DST_EXP_W{1'b1}}, nan_pay};
      default:  mag = '0;
    endcase
  end

  assign dst_o = {sign, mag};
endmodule

// File: rtl/fp_narrow_stage.sv
module fp_narrow_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready_o = ~vld_q | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (in_ready_o && in_valid_i) data_q <= in_data_i;
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/fp_narrow_conv.sv
module fp_narrow_conv
  import fp_narrow_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [31:0] in_bits_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [15:0] out_bits_o
);
  logic [DST_W-1:0] conv;

  fp_narrow_core i_core (
    .src_i (in_bits_i),
    .dst_o (conv)
  );

  fp_narrow_stage #(.W(DST_W)) i_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (conv),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_bits_o)
  );
endmodule

// File: rtl/fp_narrow_conv_chk.sv
module fp_narrow_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [31:0] in_bits_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [15:0] out_bits_o
);
  logic       fire;
  logic [7:0] iexp;
  logic [4:0] oexp;
  assign fire = in_valid_i && in_ready_o;
  assign iexp = in_bits_i[30:23];
  assign oexp = out_bits_o[14:10];

  AST_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_bits_o[15] == $past(in_bits_i[31]));  // R1

  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iexp >= 8'd143 && iexp != 8'd255 |=> out_bits_o[14:0] == 15'h7c00);  // R2

  AST_NAN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iexp == 8'd255 && in_bits_i[22:0] != '0
      |=> oexp == 5'h1f && out_bits_o[9:0] != '0);  // R3

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iexp < 8'd102 |=> out_bits_o[14:0] == '0);  // R4

  AST_REBIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iexp >= 8'd113 && iexp <= 8'd141
      |=> (8'(oexp) == $past(iexp) - 8'd112) || (8'(oexp) == $past(iexp) - 8'd111));  // R6

  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);  // R9

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_bits_o));  // R9

  AST_STALL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);  // R9

  always_comb begin
    if (!rst_ni) AST_RESET_IDLE: assert (!out_valid_o);  // R10
  end
endmodule

bind fp_narrow_conv fp_narrow_conv_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_bits_i   (in_bits_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_bits_o  (out_bits_o)
);

// File: tb/test_fp_narrow_conv.sv
`timescale 1ns/1ps
module test_fp_narrow_conv;
  localparam int ND = 28;
  localparam int NR = 3000;
  localparam int WD = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_bits = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_bits;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_narrow_conv i_fp_narrow_conv (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready), .in_bits_i (in_bits),
    .out_valid_o (out_valid), .out_ready_i (out_ready), .out_bits_o (out_bits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit s, input int e, input logic [22:0] m);
    return {s, 8'(e), m};
  endfunction

  // reference written the "add half, then truncate" way
  function automatic logic [15:0] ref_half(input logic [31:0] f);
    logic [15:0] sg;
    logic [7:0]  e;
    logic [31:0] m, sig;
    logic [15:0] r;
    sg = {f[31], 15'h0};
    e  = f[30:23];
    m  = {9'h0, f[22:0]};
    if (e == 8'hff) begin
      if (m == 0) return sg | 16'h7c00;
      r = 16'h7c00 | 16'(m >> 13);
      if (r == 16'h7c00) r = 16'h7c01;
      return sg | r;
    end
    if (e >= 8'd143) return sg | 16'h7c00;
    if (e < 8'd102) return sg;
    if (e <= 8'd112) begin
      sig = (32'h0080_0000 + m) >> (113 - int'(e));
      if ((sig & 32'h3fff) != 32'h1000 || (m & 32'h7ff) != 0) sig = sig + 32'h1000;
      return sg + 16'(sig >> 13);
    end
    sig = m;
    if ((sig & 32'h3fff) != 32'h1000) sig = sig + 32'h1000;
    return sg + 16'((32'(e) - 32'd112) << 10) + 16'(sig >> 13);
  endfunction

  function automatic string req_of(input logic [31:0] f);
    logic [7:0] e;
    e = f[30:23];
    if (e == 8'hff) return (f[22:0] == 0) ? "R2" : "R3";
    if (e >= 8'd143) return "R2";
    if (e < 8'd102) return "R4";
    if (e <= 8'd112) return "R5";
    if (e == 8'd142 && ref_half(f)[14:0] == 15'h7c00) return "R8";
    if (f[13:0] == 14'h1000 || f[13:0] == 14'h3000) return "R7";
    return "R6";
  endfunction

  logic [31:0] dvec [ND];
  logic [31:0] srcq [$];

  function automatic logic [31:0] rnd_vec();
    logic [31:0] v;
    v = $urandom;
    if ($urandom % 2 == 0) v[30:23] = 8'(96 + $urandom % 56);
    if ($urandom % 8 == 0) v[12:0] = 13'h1000;
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int idx;
    bit acc_prev, stall_prev;
    logic [15:0] held;
    logic [31:0] src;
    void'($urandom(32'd20240611));

    dvec[0]  = mk(0, 101, 23'h7fffff);  dvec[1]  = mk(1, 101, 23'h0);
    dvec[2]  = mk(0, 102, 23'h0);       dvec[3]  = mk(0, 102, 23'h1);
    dvec[4]  = mk(1, 102, 23'h7fffff);  dvec[5]  = mk(0, 112, 23'h0);
    dvec[6]  = mk(0, 112, 23'h7fffff);  dvec[7]  = mk(0, 111, 23'h001000);
    dvec[8]  = mk(0, 113, 23'h0);       dvec[9]  = mk(0, 113, 23'h001000);
    dvec[10] = mk(0, 113, 23'h003000);  dvec[11] = mk(0, 127, 23'h0);
    dvec[12] = mk(1, 127, 23'h001001);  dvec[13] = mk(0, 142, 23'h7fe000);
    dvec[14] = mk(0, 142, 23'h7ff000);  dvec[15] = mk(1, 142, 23'h7fefff);
    dvec[16] = mk(0, 143, 23'h0);       dvec[17] = mk(1, 254, 23'h123456);
    dvec[18] = mk(0, 255, 23'h0);       dvec[19] = mk(1, 255, 23'h400000);
    dvec[20] = mk(0, 255, 23'h1);       dvec[21] = mk(1, 255, 23'h7fffff);
    dvec[22] = mk(0, 0, 23'h0);         dvec[23] = mk(1, 0, 23'h0);
    dvec[24] = mk(1, 112, 23'h003fff);  dvec[25] = mk(0, 110, 23'h400000);
    dvec[26] = mk(0, 141, 23'h7ff000);  dvec[27] = mk(1, 120, 23'h005000);

    // reset with a pending input: nothing may be taken
    in_valid = 1'b1;
    in_bits  = dvec[11];
    repeat (4) begin
      @(negedge clk);
      chk("R10", 32'(out_valid), 32'd0, "valid during reset");
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 32'(out_valid), 32'd0, "valid after reset");

    idx = 0; acc_prev = 0; stall_prev = 0; held = '0;
    while (idx < ND + NR || srcq.size() != 0) begin
      @(negedge clk);
      if (stall_prev) begin
        chk("R9", 32'(out_valid), 32'd1, "valid held in stall");
        chk("R9", 32'(out_bits), 32'(held), "data held in stall");
      end
      if (acc_prev) begin
        chk("R9", 32'(out_valid), 32'd1, "valid one cycle after accept");
        in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      if (!in_valid && idx < ND + NR && ($urandom % 5) != 0) begin
        in_valid = 1'b1;
        in_bits  = (idx < ND) ? dvec[idx] : rnd_vec();
      end
      #1;
      stall_prev = out_valid && !out_ready;
      held = out_bits;
      if (stall_prev) chk("R9", 32'(in_ready), 32'd0, "ready low in stall");
      if (out_valid && out_ready) begin
        src = srcq.pop_front();
        chk("R1", 32'(out_bits[15]), 32'(src[31]), "sign");
        chk(req_of(src), 32'(out_bits), 32'(ref_half(src)), $sformatf("convert %h", src));
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        srcq.push_back(in_bits);
        idx++;
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule